// File: doc/BRIEF.md
# Clock Synthesizer Sleep/Wake Controller

This block is the digital control that sits around a clock synthesizer. Software uses a two-register window to request sleep, to choose how long the clock must settle after wake-up, and to stage a new multiplier word. Once sleep is requested, a fixed countdown runs on the system clock and then the gated system clock is switched off. A wake-up event starts a settling interval. The interval is counted in periods of the free-running 32 kHz reference clock. When it ends, the gated clock comes back and the staged multiplier has been applied. The synthesizer itself is modelled by the free-running `clk` input, and the oscillator is assumed to be already running, so no startup interval is added.

The reference clock level passes through a two-flop synchronizer into the system domain and can be read back. Software can therefore poll for its high and low phases before it writes. A wake-up event that arrives during the shutdown countdown cancels the shutdown, and the clock keeps running.

Top module: `pll_sleep_ctrl`

## Requirements
- R1: After reset the gated clock runs on every cycle, `clk_stable` is 1, `asleep` is 0, the control register reads 0x0000, and `pll_mult` equals MULT_RESET (0x0123). The frequency register reads 0x0123 on every bit except bit 7.
- R2: A write to offset 0 with bit 3 set, made while running, starts shutdown. Counting from the write edge, `sys_clk_out` gives exactly 30 more rising edges and then none. At that point `asleep` reads 1.
- R3: `sys_clk_out` is high only while `clk` is high. Its enable changes only while `clk` is low, so every pulse is a full `clk` high phase and no pulse is shortened.
- R4: Bit 7 of the frequency register (offset 2) reads the level of `ref_clk_in` after a two-flop synchronizer. Software writes to bit 7 are ignored.
- R5: A write to offset 2 is stored at once as the pending multiplier and reads back immediately. `pll_mult` changes only when a wake-up event leaves sleep, and it then takes the pending value.
- R6: A wake-up event during sleep starts a settling interval of 2^(WKSEL+1) rising edges of the reference clock, where WKSEL is control bits [10:8]. The gated clock resumes after that many edges and not before.
- R7: `clk_stable` is 0 from the shutdown write until the settling interval has expired, and it is 1 at all other times.
- R8: A wake-up event during the 30-cycle countdown cancels the shutdown. No gated pulse is lost, and `clk_stable` returns to 1 on the next cycle.
- R9: Control bit 3 reads 1 from the shutdown write until the clock is running again, and 0 otherwise. A write of bit 3 when not running, or a wake-up event while running, has no effect on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running synthesizer output (modelled) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | 32 kHz reference clock, asynchronous to `clk` |
| wake_evt | input | 1 | Wake-up event, one or more `clk` cycles high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 2 frequency |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| sys_clk_out | output | 1 | Gated system clock |
| clk_stable | output | 1 | Clock running and settled |
| asleep | output | 1 | Gated clock is off (sleep or settling) |
| pll_mult | output | 16 | Multiplier word applied to the synthesizer |

## Verification
The assertions assume that `ref_clk_in` is much slower than `clk`, so that every high and low phase lasts more than the synchronizer depth. They also assume that `wake_evt` and register strokes are synchronous to `clk` and that `clk` keeps toggling through sleep, so the countdown and the edge detector keep working. The stimulus drives the reference as a square wave of 20 `clk` periods on falling `clk` edges. It places each wake-up event just after a reference fall, so that no reference rise is still inside the synchronizer when settling begins. That makes the expected edge count exact.

// File: rtl/pll_sc_pkg.sv
package pll_sc_pkg;

  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_DRAIN  = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_SETTLE = 2'd3
  } pwr_state_e;

  // number of reference rising edges to wait for a given settle selector
  function automatic int unsigned settle_periods(input int unsigned sel);
    return 32'd1 << (sel + 32'd1);
  endfunction

  // one-hot mask for a single register bit
  function automatic logic [31:0] bit_mask(input int unsigned pos);
    return 32'd1 << pos;
  endfunction

endpackage

// File: rtl/pll_sc_refsync.sv
module pll_sc_refsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_lvl,
  output logic ref_rise
);

  logic [STAGES-1:0] chain;
  logic              lvl_d;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= ref_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= chain[STAGES-1];
  end

  assign ref_lvl  = chain[STAGES-1];
  assign ref_rise = ref_lvl & ~lvl_d;

  // R4: the synchronized level is the input seen STAGES edges earlier
  p_rise_tracks_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |-> $past(ref_in, STAGES));

endmodule

// File: rtl/pll_sc_fsm.sv
module pll_sc_fsm
  import pll_sc_pkg::*;
#(
  parameter int DRAIN_CYCLES = 30,
  parameter int WK_W         = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic            wake_evt,
  input  logic            ref_rise,
  input  logic [WK_W-1:0] wksel,
  output logic            gate_req,
  output logic            settle_start,
  output logic            clk_stable,
  output logic            asleep
);

  localparam int DRAIN_W = $clog2(DRAIN_CYCLES + 1);
  localparam int SET_W   = (1 << WK_W) + 1;

  pwr_state_e         state, nxt;
  logic [DRAIN_W-1:0] drain_cnt;
  logic [SET_W-1:0]   settle_cnt, settle_tgt;
  logic               drain_last, settle_last;

  assign drain_last  = (drain_cnt == DRAIN_W'(DRAIN_CYCLES - 1));
  assign settle_last = ref_rise && ((settle_cnt + SET_W'(1)) == settle_tgt);

  always_comb begin
    nxt = state;
    unique case (state)
      PS_RUN:    if (sleep_req)        nxt = PS_DRAIN;
      PS_DRAIN:  if (wake_evt)         nxt = PS_RUN;
                 else if (drain_last)  nxt = PS_SLEEP;
      PS_SLEEP:  if (wake_evt)         nxt = PS_SETTLE;
      PS_SETTLE: if (settle_last)      nxt = PS_RUN;
      default:                         nxt = PS_RUN;
    endcase
  end

  assign settle_start = (state == PS_SLEEP) && wake_evt;
  assign gate_req     = (state == PS_RUN) || (state == PS_DRAIN);
  assign asleep       = (state == PS_SLEEP) || (state == PS_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PS_RUN;
      drain_cnt  <= '0;
      settle_cnt <= '0;
      settle_tgt <= '0;
      clk_stable <= 1'b1;
    end else begin
      state      <= nxt;
      clk_stable <= (nxt == PS_RUN);
      drain_cnt  <= (state == PS_DRAIN) ? drain_cnt + DRAIN_W'(1) : '0;
      if (settle_start) begin
        settle_cnt <= '0;
        settle_tgt <= SET_W'(settle_periods(32'(wksel)));
      end else if ((state == PS_SETTLE) && ref_rise) begin
        settle_cnt <= settle_cnt + SET_W'(1);
      end
    end
  end

  // checker state: cycles spent draining, reference edges seen while settling
  logic [DRAIN_W-1:0] drain_age;
  logic [SET_W-1:0]   rises_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_age  <= '0;
      rises_seen <= '0;
    end else begin
      drain_age  <= (state == PS_DRAIN) ? drain_age + DRAIN_W'(1) : '0;
      rises_seen <= (state == PS_SETTLE) ? rises_seen + SET_W'(ref_rise) : '0;
    end
  end

  // R2: sleep begins after exactly DRAIN_CYCLES countdown cycles
  p_drain_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> (drain_age == DRAIN_W'(DRAIN_CYCLES)));

  // R6: the clock leaves settling after the programmed number of reference edges
  p_settle_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> (rises_seen == settle_tgt));

  // R7: the stable flag is low whenever the clock is draining or off
  p_stable_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep || (state == PS_DRAIN)) |-> !clk_stable);

  // R8: a wake during the countdown keeps the clock running
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_DRAIN) && wake_evt) |=> (clk_stable && !asleep && gate_req));

  // R9: a wake while running changes nothing
  p_run_ignores_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_RUN) && wake_evt && !sleep_req) |=> clk_stable);

endmodule

// File: rtl/pll_sc_clkgate.sv
module pll_sc_clkgate (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_req,
  output logic gclk
);

  logic en_q;
  logic en_at_rise;

  // enable moves only on the falling edge, i.e. while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= gate_req;
  end

  assign gclk = clk & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_at_rise <= 1'b1;
    else        en_at_rise <= en_q;
  end

  // R3: enable seen at a rising edge is unchanged through the high phase
  p_glitch_free_r3: assert property (@(negedge clk) disable iff (!rst_n)
    en_q == en_at_rise);

endmodule

// File: rtl/pll_sleep_ctrl.sv
module pll_sleep_ctrl
  import pll_sc_pkg::*;
#(
  parameter int                DATA_W       = 16,
  parameter int                ADDR_W       = 2,
  parameter int                WK_W         = 3,
  parameter int                WK_LSB       = 8,
  parameter int                DIS_BIT      = 3,
  parameter int                REF_BIT      = 7,
  parameter int                DRAIN_CYCLES = 30,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [DATA_W-1:0] MULT_RESET   = 16'h0123
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk_in,
  input  logic              wake_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_clk_out,
  output logic              clk_stable,
  output logic              asleep,
  output logic [DATA_W-1:0] pll_mult
);

  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] FREQ_OFS = ADDR_W'(2);
  localparam logic [DATA_W-1:0] REF_MASK = DATA_W'(bit_mask(REF_BIT));

  logic              wr_ctrl, wr_freq, sleep_req;
  logic [WK_W-1:0]   wksel_q;
  logic [DATA_W-1:0] freq_pend, mult_q, rd_img;
  logic              ref_lvl, ref_rise;
  logic              gate_req, settle_start;

  assign wr_ctrl   = reg_wr && (reg_addr == CTRL_OFS);
  assign wr_freq   = reg_wr && (reg_addr == FREQ_OFS);
  assign sleep_req = wr_ctrl && reg_wdata[DIS_BIT];

  pll_sc_refsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_clk_in),
    .ref_lvl  (ref_lvl),
    .ref_rise (ref_rise)
  );

  pll_sc_fsm #(.DRAIN_CYCLES(DRAIN_CYCLES), .WK_W(WK_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .wake_evt     (wake_evt),
    .ref_rise     (ref_rise),
    .wksel        (wksel_q),
    .gate_req     (gate_req),
    .settle_start (settle_start),
    .clk_stable   (clk_stable),
    .asleep       (asleep)
  );

  pll_sc_clkgate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_req (gate_req),
    .gclk     (sys_clk_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wksel_q   <= '0;
      freq_pend <= MULT_RESET & ~REF_MASK;
      mult_q    <= MULT_RESET;
    end else begin
      if (wr_ctrl)      wksel_q   <= reg_wdata[WK_LSB +: WK_W];
      if (wr_freq)      freq_pend <= reg_wdata & ~REF_MASK;
      if (settle_start) mult_q    <= freq_pend;
    end
  end

  always_comb begin
    rd_img = '0;
    if (reg_addr == CTRL_OFS) begin
      rd_img[WK_LSB +: WK_W] = wksel_q;
      rd_img[DIS_BIT]        = ~clk_stable;
    end else if (reg_addr == FREQ_OFS) begin
      rd_img          = freq_pend;
      rd_img[REF_BIT] = ref_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_img;
  end

  assign pll_mult = mult_q;

  // R5: the applied multiplier only moves when sleep is left
  p_mult_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !settle_start |=> $stable(pll_mult));

  // R2: shutdown never starts without a disable write
  p_sleep_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stable && !sleep_req) |=> clk_stable);

endmodule

// File: tb/pll_sleep_ctrl_test.sv
module pll_sleep_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic        wake = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic        sys_clk_out, clk_stable, asleep;
  logic [15:0] pll_mult;

  int checks = 0;
  int errors = 0;
  int gcnt = 0;
  int refcnt = 0;
  int clkcnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    logic [15:0] mask;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];

  pll_sleep_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_clk_in  (ref_in),
    .wake_evt    (wake),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .sys_clk_out (sys_clk_out),
    .clk_stable  (clk_stable),
    .asleep      (asleep),
    .pll_mult    (pll_mult)
  );

  always #10 clk = ~clk;

  always @(posedge sys_clk_out) gcnt++;
  always @(posedge ref_in) refcnt++;
  always @(posedge clk) clkcnt++;

  // reference clock: 20 clk periods, driven on falling clk edges
  initial begin
    forever begin
      repeat (10) @(negedge clk);
      ref_in = ~ref_in;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares registered read data one cycle after the address
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      rd_item_t it;
      it = sb.pop_front();
      check((reg_rdata & it.mask) == (it.exp & it.mask), it.tag,
            int'(reg_rdata & it.mask), int'(it.exp & it.mask));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp,
                    input logic [15:0] mask, input string tag);
    rd_item_t it;
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1;
    it.exp = exp; it.mask = mask; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // wake just after a reference fall, return reference rises seen before the clock resumes
  task automatic wake_measure(output int rises, output bit st_low);
    int rc0, g, n;
    @(negedge ref_in);
    @(negedge clk);
    rc0 = refcnt;
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    st_low = !clk_stable && asleep;
    g = gcnt;
    n = 0;
    while (gcnt == g && n < 20000) begin
      @(negedge clk);
      n++;
    end
    rises = refcnt - rc0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    int g0, c0, g1, rises;
    bit st_low;

    cyc(5);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    check(clk_stable == 1'b1, "R1 stable after reset", clk_stable, 1);
    check(asleep == 1'b0, "R1 awake after reset", asleep, 0);
    check(pll_mult == 16'h0123, "R1 multiplier reset", pll_mult, 16'h0123);
    rd(2'd0, 16'h0000, 16'hFFFF, "R1 control reads zero");
    rd(2'd2, 16'h0123, 16'hFF7F, "R1 frequency reset");
    g0 = gcnt;
    cyc(10);
    check(gcnt - g0 == 10, "R1 R3 clock runs each cycle", gcnt - g0, 10);

    // R4 reference level readback
    @(posedge ref_in);
    cyc(4);
    rd(2'd2, 16'h0080, 16'h0080, "R4 ref high");
    @(negedge ref_in);
    cyc(4);
    rd(2'd2, 16'h0000, 16'h0080, "R4 ref low");

    // R5 staged multiplier, bit 7 ignored
    wr(2'd2, 16'h5ABC);
    rd(2'd2, 16'h5A3C, 16'hFF7F, "R5 R4 pending readback");
    check(pll_mult == 16'h0123, "R5 multiplier held while running", pll_mult, 16'h0123);

    // R9 wake while running ignored
    g0 = gcnt;
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    cyc(8);
    check(gcnt - g0 == 10, "R9 wake in run keeps clock", gcnt - g0, 10);
    check(clk_stable == 1'b1, "R9 wake in run keeps stable", clk_stable, 1);

    // R2 shutdown with WKSEL=0
    wr(2'd0, 16'h0008);
    g0 = gcnt;
    cyc(3);
    check(clk_stable == 1'b0, "R7 stable low during countdown", clk_stable, 0);
    rd(2'd0, 16'h0008, 16'hFFFF, "R9 disable bit reads one");
    cyc(50);
    check(gcnt - g0 == 30, "R2 pulses after disable write", gcnt - g0, 30);
    check(asleep == 1'b1, "R2 asleep", asleep, 1);
    check(pll_mult == 16'h0123, "R5 multiplier held in sleep", pll_mult, 16'h0123);
    g1 = gcnt;
    cyc(20);
    check(gcnt == g1, "R2 R3 no pulses in sleep", gcnt - g1, 0);

    // R6 wake with WKSEL=0 -> 2 reference edges
    wake_measure(rises, st_low);
    check(st_low, "R7 stable low while settling", st_low, 1);
    check(rises == 2, "R6 settle edges wksel0", rises, 2);
    cyc(2);
    check(clk_stable == 1'b1, "R7 stable after settling", clk_stable, 1);
    check(pll_mult == 16'h5A3C, "R5 multiplier applied on wake", pll_mult, 16'h5A3C);
    rd(2'd0, 16'h0000, 16'hFFFF, "R9 disable bit cleared");
    g0 = gcnt;
    cyc(10);
    check(gcnt - g0 == 10, "R3 clock full rate after wake", gcnt - g0, 10);

    // R6 with WKSEL=2 -> 8 reference edges, R9 bit 3 write ignored in sleep
    wr(2'd0, 16'h0208);
    cyc(40);
    wr(2'd0, 16'h0200);
    cyc(5);
    check(asleep == 1'b1, "R9 clear write in sleep ignored", asleep, 1);
    wake_measure(rises, st_low);
    check(rises == 8, "R6 settle edges wksel2", rises, 8);
    cyc(2);
    rd(2'd0, 16'h0200, 16'hFFFF, "R6 settle field readback");
    check(pll_mult == 16'h5A3C, "R5 multiplier unchanged without write", pll_mult, 16'h5A3C);

    // R8 abort during countdown
    wr(2'd0, 16'h0208);
    g0 = gcnt;
    c0 = clkcnt;
    cyc(10);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    cyc(50);
    check(gcnt - g0 == clkcnt - c0, "R8 no pulse lost on abort", gcnt - g0, clkcnt - c0);
    check(clk_stable == 1'b1, "R8 stable after abort", clk_stable, 1);
    check(asleep == 1'b0, "R8 awake after abort", asleep, 0);
    rd(2'd0, 16'h0200, 16'hFFFF, "R8 R9 disable bit cleared by abort");

    cyc(3);
    check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule